// File: doc/BRIEF.md
# Dual-Bank Vectored Interrupt Controller

This block gathers 32 level-type interrupt request lines and presents them to a processor through two independent output banks: a normal bank and a fast bank. Each request line first passes through a shared conditioning stage. That stage can invert the line per bit and can hold the line pending until software acknowledges it. Each bank then masks the conditioned requests with its own enable set and its own priority ceiling. It raises its processor interrupt while anything qualifies, and it reports the number of the winning line.

Software reaches every register over a simple 32-bit bus. The bus has a select, a write strobe, a 12-bit byte address, write data and combinational read data. The interrupt handler loops on a bank's status word until it reads zero. On each pass it reads the current-vector word to learn which line to service. Reading a bank's acknowledge word is itself the acknowledge, and it releases latched requests.

Top module: `dual_bank_intc`

## Requirements
- R1: After reset every enable bit, both ceilings, all polarity bits, all latch-select bits and all line priorities read zero, both interrupt outputs are low, and both current words read 0.
- R2: Address map. The normal bank is at base 0x000 and the fast bank at base 0x100. Within a bank: status +0x00, raw +0x04, enable +0x08, disable +0x0C (write-only, reads 0), current +0x20, acknowledge +0x28 (reads 0), ceiling +0x2C (bits 3:0). Shared words: polarity at 0x200, latch-select at 0x204, and line n's priority at 0x300+4*n (bits 3:0). Any other address reads 0, and writes to it change nothing.
- R3: Writing the enable word sets the enable bits where the data has 1s. Writing the disable word clears the enable bits where the data has 1s. Zero data bits leave enables unchanged. Reading the enable word returns the mask.
- R4: For a polarity bit of 1 the line is used as driven, and for 0 it is inverted. A request driven before a clock edge is visible in the registers after that edge.
- R5: A line whose latch-select bit is 1 stays pending after its input goes inactive, until an acknowledge releases it. A line whose bit is 0 follows its conditioned level.
- R6: The raw word shows the conditioned requests regardless of enables, and it reads the same in both banks.
- R7: A line is in a bank's status when it is pending, enabled in that bank, and its priority value is at most the bank ceiling. A bank's interrupt output is high exactly when its status is nonzero.
- R8: The current word returns the status line with the smallest priority value. On equal values it returns the lowest line number. It reads 0 when the status is zero.
- R9: Reading a bank's acknowledge word releases the latched state of the lines enabled in that bank. A latched line whose conditioned input is still active stays pending. Latched lines not enabled in that bank are untouched.
- R10: The enable mask and ceiling of one bank have no effect on the other bank's status, current word or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 32 | Interrupt request lines |
| bus_sel_i | input | 1 | Bus access in this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the access cycle |
| irq_norm_o | output | 1 | Normal bank interrupt |
| irq_fast_o | output | 1 | Fast bank interrupt |

## Verification
Arbitration is driven with two lines sharing a priority value and with lower-numbered lines of worse priority. A selector that scans in the wrong direction, or that uses a strict comparison, returns the wrong vector. A line latches from a one-cycle pulse, and each bank is then acknowledged in turn. Clearing every latch, or clearing none, leaves the raw word wrong after the first acknowledge. An acknowledge is also issued while the input is still held active, which catches a design that loses a live request. Ceilings are set differently in the two banks and a write of all zeros goes to the enable word, so that leakage between the banks or a plain load instead of a bit-set shows at the status words.

// File: rtl/idb_pkg.sv
package idb_pkg;
  localparam int unsigned LINES  = 32;
  localparam int unsigned PRIO_W = 4;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;

  // address pages (bits 11:8)
  localparam logic [3:0] PAGE_SHARED = 4'h2;
  localparam logic [3:0] PAGE_PRIO   = 4'h3;

  // shared page offsets
  localparam logic [7:0] OFF_POL   = 8'h00;
  localparam logic [7:0] OFF_LATCH = 8'h04;

  typedef enum logic [2:0] {
    BR_NONE,
    BR_STATUS,
    BR_RAW,
    BR_EN_SET,
    BR_EN_CLR,
    BR_CUR,
    BR_ACK,
    BR_CEIL
  } bank_reg_e;

  function automatic bank_reg_e decode_bank_off(input logic [7:0] off);
    bank_reg_e r;
    case (off)
      8'h00:   r = BR_STATUS;
      8'h04:   r = BR_RAW;
      8'h08:   r = BR_EN_SET;
      8'h0C:   r = BR_EN_CLR;
      8'h20:   r = BR_CUR;
      8'h28:   r = BR_ACK;
      8'h2C:   r = BR_CEIL;
      default: r = BR_NONE;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/idb_condition.sv
module idb_condition #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] sticky_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] cond_o
);
  logic [N-1:0] req_q;
  logic [N-1:0] latch_q, latch_d;
  logic [N-1:0] level;

  always_comb begin
    level   = req_q ^ ~pol_i;
    latch_d = sticky_i & ((latch_q & ~clr_i) | level);
    cond_o  = level | (sticky_i & latch_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= '0;
      latch_q <= '0;
    end else begin
      req_q   <= req_i;
      latch_q <= latch_d;
    end
  end

  // R5: a latched pending line not being released stays pending
  p_sticky_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    |(cond_o & sticky_i & ~clr_i) |=>
      (((cond_o | ~sticky_i) & $past(cond_o & sticky_i & ~clr_i))
        == $past(cond_o & sticky_i & ~clr_i)));

  // R9: a released line with no active level drops its latch
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    |(clr_i & ~level) |=> ((latch_q & $past(clr_i & ~level)) == '0));
endmodule

// File: rtl/idb_arbiter.sv
module idb_arbiter #(
  parameter int unsigned N  = 32,
  parameter int unsigned PW = 4,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         qual_i,
  input  logic [N-1:0][PW-1:0] prio_i,
  output logic                 valid_o,
  output logic [IW-1:0]        idx_o
);
  logic [PW-1:0] best;

  // scan from the top line down; "<=" lets lower numbers win ties
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    best    = '1;
    for (int i = N - 1; i >= 0; i--) begin
      if (qual_i[i] && (!valid_o || prio_i[i] <= best)) begin
        valid_o = 1'b1;
        best    = prio_i[i];
        idx_o   = IW'(i);
      end
    end
  end

  p_win_qualified_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> qual_i[idx_o]);

  p_any_gives_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|qual_i) |-> valid_o);

  for (genvar g = 0; g < N; g++) begin : g_chk
    p_no_better_r8: assert property (@(posedge clk) disable iff (!rst_n)
      qual_i[g] |-> ((prio_i[g] > prio_i[idx_o]) ||
                     ((prio_i[g] == prio_i[idx_o]) && (IW'(g) >= idx_o))));
  end
endmodule

// File: rtl/idb_bank.sv
module idb_bank #(
  parameter int unsigned N  = 32,
  parameter int unsigned PW = 4,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         cond_i,
  input  logic [N-1:0][PW-1:0] prio_i,
  input  logic                 set_we_i,
  input  logic                 clr_we_i,
  input  logic                 ceil_we_i,
  input  logic                 ack_i,
  input  logic [N-1:0]         mask_data_i,
  input  logic [PW-1:0]        ceil_data_i,
  output logic [N-1:0]         en_o,
  output logic [PW-1:0]        ceil_o,
  output logic [N-1:0]         status_o,
  output logic [IW-1:0]        cur_o,
  output logic                 irq_o,
  output logic [N-1:0]         latch_clr_o
);
  logic [N-1:0]  en_q, en_d;
  logic          en_ce;
  logic [PW-1:0] ceil_q;
  logic [N-1:0]  in_range;
  logic          win_valid;
  logic [IW-1:0] win_idx;

  always_comb begin
    en_ce = set_we_i | clr_we_i;
    en_d  = en_q;
    if (set_we_i)      en_d = en_q | mask_data_i;
    else if (clr_we_i) en_d = en_q & ~mask_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ceil_q <= '0;
    else if (ceil_we_i) ceil_q <= ceil_data_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_range
    assign in_range[g] = (prio_i[g] <= ceil_q);
  end

  assign status_o    = cond_i & en_q & in_range;
  assign irq_o       = |status_o;
  assign en_o        = en_q;
  assign ceil_o      = ceil_q;
  assign latch_clr_o = ack_i ? en_q : '0;

  idb_arbiter #(.N(N), .PW(PW)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .qual_i  (status_o),
    .prio_i  (prio_i),
    .valid_o (win_valid),
    .idx_o   (win_idx)
  );

  assign cur_o = win_valid ? win_idx : '0;

  p_enable_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_we_i |=> ((en_q & $past(mask_data_i)) == $past(mask_data_i)));

  p_enable_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we_i |=> ((en_q & $past(mask_data_i)) == '0));

  p_enable_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_we_i || clr_we_i) |=> $stable(en_q));

  p_ceiling_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ceil_we_i |=> (ceil_q == $past(ceil_data_i)));
endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
  import idb_pkg::*;
#(
  parameter int unsigned N_LINES   = LINES,
  parameter int unsigned PRIO_BITS = PRIO_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] req_i,
  input  logic               bus_sel_i,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic               irq_norm_o,
  output logic               irq_fast_o
);
  localparam int unsigned NBANK = 2;
  localparam int unsigned IDXW  = $clog2(N_LINES);

  logic [3:0]      page;
  logic [7:0]      off;
  bank_reg_e       breg;
  logic            rd_acc, wr_acc;

  logic [N_LINES-1:0]                pol_q, stk_q;
  logic [N_LINES-1:0][PRIO_BITS-1:0] prio_q;
  logic            pol_ce, stk_ce, prio_ce, prio_hit;
  logic [IDXW-1:0] prio_sel;

  logic [N_LINES-1:0] cond, clr_all;

  logic [NBANK-1:0][N_LINES-1:0]   b_en, b_status, b_clr;
  logic [NBANK-1:0][PRIO_BITS-1:0] b_ceil;
  logic [NBANK-1:0][IDXW-1:0]      b_cur;
  logic [NBANK-1:0]                b_irq, b_hit, b_ack;

  // ---------------- address decode ----------------
  always_comb begin
    page     = bus_addr_i[11:8];
    off      = bus_addr_i[7:0];
    breg     = decode_bank_off(off);
    rd_acc   = bus_sel_i & ~bus_we_i;
    wr_acc   = bus_sel_i & bus_we_i;
    prio_sel = off[IDXW+1:2];
    prio_hit = (page == PAGE_PRIO) && (off[1:0] == 2'b00) &&
               (off[7:IDXW+2] == '0) && (int'(prio_sel) < int'(N_LINES));
    pol_ce   = wr_acc && (page == PAGE_SHARED) && (off == OFF_POL);
    stk_ce   = wr_acc && (page == PAGE_SHARED) && (off == OFF_LATCH);
    prio_ce  = wr_acc && prio_hit;
  end

  // ---------------- shared configuration ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pol_q <= '0;
    else if (pol_ce) pol_q <= bus_wdata_i[N_LINES-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stk_q <= '0;
    else if (stk_ce) stk_q <= bus_wdata_i[N_LINES-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prio_q           <= '0;
    else if (prio_ce) prio_q[prio_sel] <= bus_wdata_i[PRIO_BITS-1:0];
  end

  // ---------------- request conditioning ----------------
  always_comb begin
    clr_all = '0;
    for (int b = 0; b < int'(NBANK); b++) clr_all = clr_all | b_clr[b];
  end

  idb_condition #(.N(N_LINES)) u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .pol_i    (pol_q),
    .sticky_i (stk_q),
    .clr_i    (clr_all),
    .cond_o   (cond)
  );

  // ---------------- output banks ----------------
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign b_hit[b] = (page == 4'(b));
    assign b_ack[b] = rd_acc && b_hit[b] && (breg == BR_ACK);

    idb_bank #(.N(N_LINES), .PW(PRIO_BITS)) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .cond_i      (cond),
      .prio_i      (prio_q),
      .set_we_i    (wr_acc && b_hit[b] && (breg == BR_EN_SET)),
      .clr_we_i    (wr_acc && b_hit[b] && (breg == BR_EN_CLR)),
      .ceil_we_i   (wr_acc && b_hit[b] && (breg == BR_CEIL)),
      .ack_i       (b_ack[b]),
      .mask_data_i (bus_wdata_i[N_LINES-1:0]),
      .ceil_data_i (bus_wdata_i[PRIO_BITS-1:0]),
      .en_o        (b_en[b]),
      .ceil_o      (b_ceil[b]),
      .status_o    (b_status[b]),
      .cur_o       (b_cur[b]),
      .irq_o       (b_irq[b]),
      .latch_clr_o (b_clr[b])
    );
  end

  assign irq_norm_o = b_irq[0];
  assign irq_fast_o = b_irq[1];

  // ---------------- read path ----------------
  always_comb begin
    bus_rdata_o = '0;
    if (rd_acc) begin
      for (int b = 0; b < int'(NBANK); b++) begin
        if (b_hit[b]) begin
          case (breg)
            BR_STATUS: bus_rdata_o = DATA_W'(b_status[b]);
            BR_RAW:    bus_rdata_o = DATA_W'(cond);
            BR_EN_SET: bus_rdata_o = DATA_W'(b_en[b]);
            BR_CUR:    bus_rdata_o = DATA_W'(b_cur[b]);
            BR_CEIL:   bus_rdata_o = DATA_W'(b_ceil[b]);
            default:   bus_rdata_o = '0;
          endcase
        end
      end
      if (page == PAGE_SHARED && off == OFF_POL)   bus_rdata_o = DATA_W'(pol_q);
      if (page == PAGE_SHARED && off == OFF_LATCH) bus_rdata_o = DATA_W'(stk_q);
      if (prio_hit) bus_rdata_o = DATA_W'(prio_q[prio_sel]);
    end
  end

  // R7: each output follows its own status word
  p_norm_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_norm_o == (b_status[0] != '0));

  // R9: an acknowledge read returns zero
  p_ack_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (b_ack != '0) |-> (bus_rdata_o == '0));
endmodule

// File: tb/sim_dual_bank_intc.sv
`timescale 1ns/1ps
module sim_dual_bank_intc;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] req;
  logic        sel, we;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq_n, irq_f;

  int nchk  = 0;
  int nfail = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  dual_bank_intc u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req),
    .bus_sel_i   (sel),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_norm_o  (irq_n),
    .irq_fast_o  (irq_f)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = '0; sel = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1; sel = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(posedge clk); #1; sel = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input string what,
                        input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_rd(a, v);
    chk(tag, what, v, exp);
  endtask

  task automatic set_req(input logic [31:0] v);
    @(negedge clk); req = v;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "irq_norm after reset", {31'b0, irq_n}, 32'h0);
    chk("R1", "irq_fast after reset", {31'b0, irq_f}, 32'h0);
    rd_chk("R1", "norm enable", 12'h008, 32'h0);
    rd_chk("R1", "fast enable", 12'h108, 32'h0);
    rd_chk("R1", "norm ceiling", 12'h02C, 32'h0);
    rd_chk("R1", "polarity", 12'h200, 32'h0);
    rd_chk("R1", "latch select", 12'h204, 32'h0);
    rd_chk("R1", "priority line 5", 12'h314, 32'h0);
    rd_chk("R1", "norm current", 12'h020, 32'h0);
    // polarity 0 inverts idle-low inputs
    rd_chk("R4", "raw after reset inverted", 12'h004, 32'hFFFF_FFFF);
  endtask

  task automatic t_polarity();
    do_reset();
    bus_wr(12'h200, 32'hFFFF_FFFF);
    rd_chk("R4", "raw with pass-through, idle", 12'h004, 32'h0);
    set_req(32'h0000_00A5);
    rd_chk("R4", "raw pass-through", 12'h004, 32'h0000_00A5);
    rd_chk("R6", "fast raw same", 12'h104, 32'h0000_00A5);
    bus_wr(12'h200, 32'hFFFF_FF00);
    rd_chk("R4", "raw low byte inverted", 12'h004, 32'h0000_005A);
  endtask

  task automatic t_enable();
    do_reset();
    bus_wr(12'h200, 32'hFFFF_FFFF);
    set_req(32'h0000_00F0);
    bus_wr(12'h008, 32'h0000_0030);
    rd_chk("R3", "enable after set", 12'h008, 32'h0000_0030);
    rd_chk("R7", "norm status", 12'h000, 32'h0000_0030);
    chk("R7", "irq_norm high", {31'b0, irq_n}, 32'h1);
    chk("R10", "irq_fast low", {31'b0, irq_f}, 32'h0);
    rd_chk("R10", "fast status", 12'h100, 32'h0);
    rd_chk("R6", "fast raw", 12'h104, 32'h0000_00F0);
    bus_wr(12'h00C, 32'h0000_0010);
    rd_chk("R3", "enable after clear", 12'h008, 32'h0000_0020);
    rd_chk("R2", "disable word reads zero", 12'h00C, 32'h0);
    bus_wr(12'h008, 32'h0000_0000);
    rd_chk("R3", "zero write keeps enables", 12'h008, 32'h0000_0020);
    rd_chk("R7", "norm status after clear", 12'h000, 32'h0000_0020);
    bus_wr(12'h00C, 32'h0000_0020);
    chk("R7", "irq_norm low", {31'b0, irq_n}, 32'h0);
  endtask

  task automatic t_arbitration();
    do_reset();
    bus_wr(12'h200, 32'hFFFF_FFFF);
    bus_wr(12'h02C, 32'h0000_000F);
    bus_wr(12'h008, 32'hFFFF_FFFF);
    bus_wr(12'h30C, 32'h5);   // line 3
    bus_wr(12'h31C, 32'h2);   // line 7
    bus_wr(12'h324, 32'h2);   // line 9
    bus_wr(12'h350, 32'h9);   // line 20
    set_req(32'h0010_0288);
    rd_chk("R8", "tie goes to line 7", 12'h020, 32'd7);
    set_req(32'h0010_0208);
    rd_chk("R8", "line 9 next", 12'h020, 32'd9);
    set_req(32'h0010_0008);
    rd_chk("R8", "line 3 beats 20", 12'h020, 32'd3);
    set_req(32'h0010_0000);
    rd_chk("R8", "line 20 alone", 12'h020, 32'd20);
    set_req(32'h0);
    rd_chk("R8", "current zero when idle", 12'h020, 32'd0);
    rd_chk("R7", "status zero when idle", 12'h000, 32'h0);
  endtask

  task automatic t_ceiling();
    do_reset();
    bus_wr(12'h200, 32'hFFFF_FFFF);
    bus_wr(12'h310, 32'h6);   // line 4
    bus_wr(12'h318, 32'h3);   // line 6
    bus_wr(12'h008, 32'hFFFF_FFFF);
    bus_wr(12'h108, 32'hFFFF_FFFF);
    bus_wr(12'h02C, 32'h3);
    bus_wr(12'h12C, 32'hF);
    set_req(32'h0000_0050);
    rd_chk("R7", "norm status under ceiling 3", 12'h000, 32'h0000_0040);
    rd_chk("R10", "fast status under ceiling F", 12'h100, 32'h0000_0050);
    rd_chk("R8", "fast current", 12'h120, 32'd6);
    bus_wr(12'h02C, 32'h2);
    rd_chk("R7", "norm status ceiling 2", 12'h000, 32'h0);
    chk("R7", "irq_norm low by ceiling", {31'b0, irq_n}, 32'h0);
    chk("R10", "irq_fast stays high", {31'b0, irq_f}, 32'h1);
    rd_chk("R2", "norm ceiling readback", 12'h02C, 32'h2);
  endtask

  task automatic t_sticky();
    do_reset();
    bus_wr(12'h200, 32'hFFFF_FFFF);
    bus_wr(12'h204, 32'h0000_0804);
    bus_wr(12'h008, 32'h0000_0004);
    bus_wr(12'h108, 32'h0000_0800);
    set_req(32'h0000_0806);
    set_req(32'h0);
    rd_chk("R5", "latched lines held, level line gone", 12'h004, 32'h0000_0804);
    rd_chk("R7", "norm status latched", 12'h000, 32'h0000_0004);
    rd_chk("R8", "norm current line 2", 12'h020, 32'd2);
    rd_chk("R9", "norm ack reads zero", 12'h028, 32'h0);
    rd_chk("R9", "norm ack released only line 2", 12'h004, 32'h0000_0800);
    chk("R9", "irq_norm low after ack", {31'b0, irq_n}, 32'h0);
    chk("R9", "irq_fast still high", {31'b0, irq_f}, 32'h1);
    rd_chk("R9", "fast ack reads zero", 12'h128, 32'h0);
    rd_chk("R9", "fast ack released line 11", 12'h004, 32'h0);
    set_req(32'h0000_0004);
    rd_chk("R9", "ack with live input", 12'h028, 32'h0);
    rd_chk("R9", "live line stays pending", 12'h004, 32'h0000_0004);
    set_req(32'h0);
    rd_chk("R5", "relatched after live ack", 12'h004, 32'h0000_0004);
    rd_chk("R9", "final ack", 12'h028, 32'h0);
    rd_chk("R9", "released", 12'h004, 32'h0);
  endtask

  task automatic t_map();
    do_reset();
    bus_wr(12'h210, 32'hFFFF_FFFF);
    bus_wr(12'h040, 32'hFFFF_FFFF);
    rd_chk("R2", "polarity untouched", 12'h200, 32'h0);
    rd_chk("R2", "latch select untouched", 12'h204, 32'h0);
    rd_chk("R2", "norm enable untouched", 12'h008, 32'h0);
    rd_chk("R2", "unmapped 0x210", 12'h210, 32'h0);
    rd_chk("R2", "unmapped 0x400", 12'h400, 32'h0);
    bus_wr(12'h37C, 32'h0000_00FF);
    rd_chk("R2", "priority line 31 width", 12'h37C, 32'hF);
    rd_chk("R2", "priority line 30 untouched", 12'h378, 32'h0);
  endtask

  initial begin
    t_reset();
    t_polarity();
    t_enable();
    t_arbitration();
    t_ceiling();
    t_sticky();
    t_map();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog all: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule